// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This unit sits between a memory port and an instruction-consuming execution stage. While there is room, it reads instruction code ahead of need, one 16-bit word per memory cycle, into a six-byte first-in first-out queue. It hands that code to the consumer one byte at a time. The memory port is shared with operand traffic from the execution side. A pending operand read or write takes the port before the next prefetch, but a fetch that is already on the bus is always allowed to finish first.

Each physical address is 20 bits wide. It is formed by shifting a 16-bit segment left by four bits and adding a 16-bit offset. A redirect (a taken branch or jump) supplies a new segment and offset. The redirect empties the queue at once. If a fetch is on the bus at that moment, its data is thrown away when it returns. Fetching then resumes at the target.

The byte output is a valid/ready stream. `byte_data` is meaningful only while `byte_valid` is high, and a byte leaves the queue on each rising edge where both `byte_valid` and `byte_ready` are high. While `byte_ready` is low the head byte is held unchanged. A redirect is the only event that may withdraw it. The consumer can raise `byte_ready` at any time, including while the queue is empty. The memory side is a plain request/acknowledge port: `mem_req` stays high with a stable address until the edge where `mem_ack` is high, and `mem_rdata` is taken at that edge.

Top module: `pfq_unit`

## Requirements
- R1: The queue holds at most six bytes and returns them in the order of their byte addresses. Bytes wait while the consumer does not take them.
- R2: A fetch reads the aligned word at an even physical address. The byte at the even address (`mem_rdata[7:0]`) enters the queue before the byte at the next address (`mem_rdata[15:8]`).
- R3: One byte is removed per edge with `byte_valid` and `byte_ready` both high. With `byte_ready` low, `byte_valid` and `byte_data` stay unchanged, unless a redirect occurs.
- R4: While the queue is empty, `byte_valid` is low and the consumer waits until a fetched byte arrives at the head.
- R5: A redirect discards every queued byte, so `byte_valid` is low in the cycle after it. The next fetch starts at the new segment:offset.
- R6: The physical address is (segment × 16 + offset) modulo 2^20. After reset, the first fetch uses segment FFFF and offset 0000, which is address FFFF0.
- R7: A fetch starts only when at least two queue bytes are free. With a full queue and no operand request, `mem_req` stays low.
- R8: A pending operand request (`opr_req`) wins the port over a new fetch, but it waits for an in-flight fetch to finish. `opr_done` pulses at its acknowledge. On a read, `opr_rdata` carries the word.
- R9: The data of a fetch that is outstanding when a redirect arrives is not written into the queue.
- R10: When the target offset is odd, the first fetch after the redirect reads the word at offset−1 and enqueues only its upper byte.
- R11: Every later fetch advances the offset by two, wrapping modulo 65536 within the same segment.
- R12: Once raised, `mem_req` stays high, with `mem_addr` and `mem_we` unchanged, until the edge that has `mem_ack` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | One-cycle redirect strobe |
| redir_seg | input | 16 | Redirect target segment |
| redir_off | input | 16 | Redirect target offset |
| byte_valid | output | 1 | Head byte available |
| byte_data | output | 8 | Head byte of the queue |
| byte_ready | input | 1 | Consumer accepts the head byte |
| opr_req | input | 1 | Operand access request, held until `opr_done` |
| opr_we | input | 1 | Operand access is a write |
| opr_seg | input | 16 | Operand segment |
| opr_off | input | 16 | Operand offset |
| opr_wdata | input | 16 | Operand write word |
| opr_done | output | 1 | Operand access acknowledged this cycle |
| opr_rdata | output | 16 | Operand read word, valid with `opr_done` |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Memory write word |
| mem_ack | input | 1 | Memory cycle completes at this edge |
| mem_rdata | input | 16 | Memory read word, valid with `mem_ack` |

## Verification
The hardest case to reach from the ports is a redirect that lands while a fetch is still waiting on the bus. Its data must return later and be thrown away without touching the queue. The bench slows the memory model's acknowledge to several cycles and waits until it sees `mem_req` high. It then issues a second redirect to an odd target and checks that the first byte delivered comes from that target's upper half-word. Operand priority is reached the same way: the operand request is raised while a slow fetch is outstanding, and the order of the acknowledged addresses is then checked.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FETCH = 2'd1,
    SEQ_OPER  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/pfq_phys_addr.sv
module pfq_phys_addr #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);
  localparam int SHIFT = ADDR_W - SEG_W;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] disp;

  // Segment shifted into paragraph units; offset zero-extended; sum wraps.
  assign base = {seg, {SHIFT{1'b0}}};
  assign disp = {{(ADDR_W-OFF_W){1'b0}}, off};
  assign phys = base + disp;
endmodule

// File: rtl/pfq_byte_queue.sv
module pfq_byte_queue #(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic                           push_two,
  input  logic [BYTE_W-1:0]              wr_lo,
  input  logic [BYTE_W-1:0]              wr_hi,
  input  logic                           pop,
  output logic [BYTE_W-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0]     level
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [BYTE_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr, wr_next;
  logic [LVL_W-1:0]  add_n, sub_n;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign wr_next = step(wr_ptr);
  assign head    = slot[rd_ptr];
  assign add_n   = push ? (push_two ? LVL_W'(2) : LVL_W'(1)) : '0;
  assign sub_n   = (pop && level != '0) ? LVL_W'(1) : '0;

  // One storage slot per generate iteration; a two-byte push lands in two slots.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !flush) begin
        if (wr_ptr == PTR_W'(i))
          slot[i] <= push_two ? wr_lo : wr_hi;
        else if (push_two && wr_next == PTR_W'(i))
          slot[i] <= wr_hi;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push)
        wr_ptr <= push_two ? step(wr_next) : wr_next;
      if (sub_n != '0)
        rd_ptr <= step(rd_ptr);
      level <= level + add_n - sub_n;
    end
  end
endmodule

// File: rtl/pfq_fetch_seq.sv
module pfq_fetch_seq
  import pfq_pkg::*;
#(
  parameter int                SEG_W   = 16,
  parameter int                OFF_W   = 16,
  parameter int                ADDR_W  = 20,
  parameter int                DATA_W  = 16,
  parameter int                DEPTH   = 6,
  parameter logic [SEG_W-1:0]  RST_SEG = '1,
  parameter logic [OFF_W-1:0]  RST_OFF = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        redir_valid,
  input  logic [SEG_W-1:0]            redir_seg,
  input  logic [OFF_W-1:0]            redir_off,
  input  logic [$clog2(DEPTH+1)-1:0]  level,
  input  logic                        opr_req,
  input  logic                        opr_we,
  input  logic [ADDR_W-1:0]           opr_phys,
  input  logic [DATA_W-1:0]           opr_wdata,
  input  logic [ADDR_W-1:0]           fetch_phys,
  input  logic                        mem_ack,
  output logic [SEG_W-1:0]            cur_seg,
  output logic [OFF_W-1:0]            fetch_off,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  output logic                        push,
  output logic                        push_two,
  output logic                        opr_done,
  output logic                        fetch_act,
  output logic                        opr_act
);
  localparam int ROOM_LIM = DEPTH - 2;
  localparam int WIP_W    = OFF_W - 1;

  seq_state_t       state;
  logic [WIP_W-1:0] ip_word;
  logic             skip_low;
  logic             drop;
  logic             room;

  assign fetch_off = {ip_word, 1'b0};
  assign room      = (int'(level) <= ROOM_LIM);
  assign fetch_act = (state == SEQ_FETCH);
  assign opr_act   = (state == SEQ_OPER);
  assign mem_req   = fetch_act || opr_act;
  assign opr_done  = opr_act && mem_ack;
  assign push      = fetch_act && mem_ack && !drop && !redir_valid;
  assign push_two  = !skip_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      cur_seg   <= RST_SEG;
      ip_word   <= RST_OFF[OFF_W-1:1];
      skip_low  <= RST_OFF[0];
      drop      <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (opr_req) begin
            state     <= SEQ_OPER;
            mem_we    <= opr_we;
            mem_addr  <= opr_phys;
            mem_wdata <= opr_wdata;
          end else if (room && !redir_valid) begin
            state    <= SEQ_FETCH;
            mem_we   <= 1'b0;
            mem_addr <= fetch_phys;
          end
        end
        SEQ_FETCH: begin
          if (mem_ack) begin
            state <= SEQ_IDLE;
            drop  <= 1'b0;
            if (!drop) begin
              ip_word  <= ip_word + WIP_W'(1);
              skip_low <= 1'b0;
            end
          end
        end
        SEQ_OPER: begin
          if (mem_ack)
            state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase

      // A redirect overrides pointer updates; an in-flight fetch is marked stale.
      if (redir_valid) begin
        cur_seg  <= redir_seg;
        ip_word  <= redir_off[OFF_W-1:1];
        skip_low <= redir_off[0];
        if (fetch_act && !mem_ack)
          drop <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfq_unit.sv
module pfq_unit #(
  parameter int          SEG_W   = 16,
  parameter int          OFF_W   = 16,
  parameter int          ADDR_W  = 20,
  parameter int          BYTE_W  = 8,
  parameter int          DEPTH   = 6,
  parameter logic [15:0] RST_SEG = 16'hFFFF,
  parameter logic [15:0] RST_OFF = 16'h0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  redir_valid,
  input  logic [SEG_W-1:0]      redir_seg,
  input  logic [OFF_W-1:0]      redir_off,
  output logic                  byte_valid,
  output logic [BYTE_W-1:0]     byte_data,
  input  logic                  byte_ready,
  input  logic                  opr_req,
  input  logic                  opr_we,
  input  logic [SEG_W-1:0]      opr_seg,
  input  logic [OFF_W-1:0]      opr_off,
  input  logic [2*BYTE_W-1:0]   opr_wdata,
  output logic                  opr_done,
  output logic [2*BYTE_W-1:0]   opr_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [2*BYTE_W-1:0]   mem_wdata,
  input  logic                  mem_ack,
  input  logic [2*BYTE_W-1:0]   mem_rdata
);
  localparam int DATA_W = 2 * BYTE_W;
  localparam int LVL_W  = $clog2(DEPTH+1);

  logic [LVL_W-1:0]  q_level;
  logic [SEG_W-1:0]  cur_seg;
  logic [OFF_W-1:0]  fetch_off;
  logic [ADDR_W-1:0] fetch_phys, opr_phys;
  logic              push, push_two, pop;
  logic              fetch_act, opr_act;

  pfq_phys_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_fetch_adr (
    .seg(cur_seg), .off(fetch_off), .phys(fetch_phys)
  );

  pfq_phys_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_opr_adr (
    .seg(opr_seg), .off(opr_off), .phys(opr_phys)
  );

  pfq_fetch_seq #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DEPTH(DEPTH), .RST_SEG(RST_SEG[SEG_W-1:0]), .RST_OFF(RST_OFF[OFF_W-1:0])
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_seg(redir_seg), .redir_off(redir_off),
    .level(q_level),
    .opr_req(opr_req), .opr_we(opr_we), .opr_phys(opr_phys), .opr_wdata(opr_wdata),
    .fetch_phys(fetch_phys), .mem_ack(mem_ack),
    .cur_seg(cur_seg), .fetch_off(fetch_off),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .push(push), .push_two(push_two), .opr_done(opr_done),
    .fetch_act(fetch_act), .opr_act(opr_act)
  );

  pfq_byte_queue #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(redir_valid),
    .push(push), .push_two(push_two),
    .wr_lo(mem_rdata[BYTE_W-1:0]), .wr_hi(mem_rdata[DATA_W-1:BYTE_W]),
    .pop(pop), .head(byte_data), .level(q_level)
  );

  assign byte_valid = (q_level != '0);
  assign pop        = byte_valid && byte_ready;
  assign opr_rdata  = mem_rdata;
endmodule

// File: rtl/pfq_unit_checker.sv
module pfq_unit_checker #(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redir_valid,
  input logic              byte_valid,
  input logic [BYTE_W-1:0] byte_data,
  input logic              byte_ready,
  input logic              opr_req,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [LVL_W-1:0]  q_level,
  input logic              fetch_act,
  input logic              opr_act
);
  assert_capacity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_level) <= DEPTH);

  assert_even_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_act |-> !mem_addr[0]);

  assert_hold_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready && !redir_valid |=> byte_valid && $stable(byte_data));

  assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !byte_valid);

  assert_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_act) |-> int'(q_level) <= DEPTH - 2);

  assert_operand_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    opr_req && !mem_req |=> opr_act);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

bind pfq_unit pfq_unit_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LVL_W($clog2(DEPTH+1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid),
  .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
  .opr_req(opr_req), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .q_level(q_level), .fetch_act(fetch_act), .opr_act(opr_act)
);

// File: tb/pfq_unit_test.sv
module pfq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  logic [15:0] redir_seg = '0, redir_off = '0;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        byte_ready = 1'b0;
  logic        opr_req = 1'b0, opr_we = 1'b0;
  logic [15:0] opr_seg = '0, opr_off = '0, opr_wdata = '0;
  logic        opr_done;
  logic [15:0] opr_rdata;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  int nchk = 0, nfail = 0;
  int lat = 0, wcnt = 0;
  int nlog = 0;
  logic [19:0] log_addr [64];
  logic        log_we   [64];
  logic [15:0] log_wd   [64];
  logic [15:0] last_rd = '0;

  always #10 clk = ~clk;

  pfq_unit uut (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_seg(redir_seg),
    .redir_off(redir_off), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .opr_req(opr_req), .opr_we(opr_we), .opr_seg(opr_seg),
    .opr_off(opr_off), .opr_wdata(opr_wdata), .opr_done(opr_done), .opr_rdata(opr_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h3C;
  endfunction

  // Memory model: acknowledges after lat idle cycles; contents from mb().
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = {mb(mem_addr + 20'd1), mb(mem_addr)};
        wcnt = 0;
      end else wcnt++;
    end else mem_ack = 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      log_addr[nlog % 64] <= mem_addr;
      log_we[nlog % 64]   <= mem_we;
      log_wd[nlog % 64]   <= mem_wdata;
      nlog <= nlog + 1;
    end
    if (rst_n && opr_done) last_rd <= opr_rdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic redirect(input logic [15:0] s, input logic [15:0] o);
    @(negedge clk);
    redir_valid = 1'b1; redir_seg = s; redir_off = o;
    @(negedge clk);
    redir_valid = 1'b0;
    chk(!byte_valid, "R5 queue empty after redirect", {31'd0, byte_valid}, 32'd0);
  endtask

  task automatic get_byte(input int gap, output logic [7:0] b);
    @(negedge clk);
    byte_ready = 1'b1;
    while (!byte_valid) @(negedge clk);
    b = byte_data;
    @(posedge clk);
    if (gap > 0) begin
      @(negedge clk);
      byte_ready = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    byte_ready = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  // seg, off, count, latency, ready gap
  localparam logic [47:0] VEC [6] = '{
    {16'h1234, 16'h0010, 8'd10, 4'd0, 4'd0},
    {16'h2000, 16'h0007, 8'd9,  4'd1, 4'd1},
    {16'h0FFF, 16'hFFFC, 8'd8,  4'd0, 4'd2},
    {16'hFFFF, 16'h0020, 8'd6,  4'd2, 4'd0},
    {16'h0040, 16'hFFFF, 8'd5,  4'd0, 4'd3},
    {16'hABCD, 16'h1235, 8'd12, 4'd3, 4'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] b, d0;
    logic [15:0] s, o;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!byte_valid, "R4 reset byte_valid low", {31'd0, byte_valid}, 32'd0);
    chk(!mem_req, "R12 reset mem_req low", {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    chk(mem_req && mem_addr == 20'hFFFF0, "R6 first fetch at reset address", {12'd0, mem_addr}, 32'hFFFF0);

    // Table of redirect targets: byte order, odd starts, offset and address wrap.
    for (int v = 0; v < 6; v++) begin
      s = VEC[v][47:32]; o = VEC[v][31:16];
      lat = int'(VEC[v][7:4]);
      redirect(s, o);
      for (int i = 0; i < int'(VEC[v][15:8]); i++) begin
        get_byte(int'(VEC[v][3:0]), b);
        chk(b == mb(phys(s, o + 16'(i))), "R2 R6 R10 R11 byte stream", {24'd0, b},
            {24'd0, mb(phys(s, o + 16'(i)))});
      end
    end

    // Full queue: three fetches then silence, head held under back-pressure.
    lat = 0;
    quiet();
    n0 = nlog;
    redirect(16'h0100, 16'h0000);
    repeat (30) @(negedge clk);
    chk(nlog - n0 == 3, "R7 fetch count to fill queue", nlog - n0, 32'd3);
    chk(!mem_req, "R7 bus idle when full", {31'd0, mem_req}, 32'd0);
    d0 = byte_data;
    chk(d0 == mb(phys(16'h0100, 16'h0000)), "R1 head is oldest byte", {24'd0, d0},
        {24'd0, mb(phys(16'h0100, 16'h0000))});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(byte_valid && byte_data == d0, "R3 head stable while not ready", {24'd0, byte_data}, {24'd0, d0});
    end
    for (int i = 0; i < 6; i++) begin
      get_byte(0, b);
      chk(b == mb(phys(16'h0100, 16'(i))), "R1 six bytes in order", {24'd0, b},
          {24'd0, mb(phys(16'h0100, 16'(i)))});
    end

    // Empty queue with slow memory: consumer waits.
    lat = 8;
    quiet();
    redirect(16'h0300, 16'h0040);
    @(negedge clk);
    byte_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!byte_valid, "R4 no byte while empty", {31'd0, byte_valid}, 32'd0);
    end
    get_byte(0, b);
    chk(b == mb(phys(16'h0300, 16'h0040)), "R4 R5 first byte after wait", {24'd0, b},
        {24'd0, mb(phys(16'h0300, 16'h0040))});

    // Redirect while a fetch is on the bus: its data must vanish.
    lat = 6;
    quiet();
    redirect(16'h0500, 16'h0000);
    while (!mem_req) @(negedge clk);
    repeat (2) @(negedge clk);
    redirect(16'h0600, 16'h0011);
    for (int i = 0; i < 4; i++) begin
      get_byte(0, b);
      chk(b == mb(phys(16'h0600, 16'h0011 + 16'(i))), "R9 R10 stale fetch dropped", {24'd0, b},
          {24'd0, mb(phys(16'h0600, 16'h0011 + 16'(i)))});
    end

    // Operand write raised during an in-flight fetch, then an operand read.
    lat = 4;
    quiet();
    redirect(16'h0700, 16'h0000);
    while (!mem_req) @(negedge clk);
    n0 = nlog;
    opr_req = 1'b1; opr_we = 1'b1; opr_seg = 16'h0800; opr_off = 16'h0003; opr_wdata = 16'hBEEF;
    while (nlog < n0 + 2) @(negedge clk);
    opr_req = 1'b0;
    chk(log_addr[n0 % 64] == phys(16'h0700, 16'h0000) && !log_we[n0 % 64],
        "R8 in-flight fetch completes first", {12'd0, log_addr[n0 % 64]}, {12'd0, phys(16'h0700, 16'h0000)});
    chk(log_addr[(n0 + 1) % 64] == phys(16'h0800, 16'h0003) && log_we[(n0 + 1) % 64],
        "R8 operand write next", {12'd0, log_addr[(n0 + 1) % 64]}, {12'd0, phys(16'h0800, 16'h0003)});
    chk(log_wd[(n0 + 1) % 64] == 16'hBEEF, "R8 operand write data", {16'd0, log_wd[(n0 + 1) % 64]}, 32'h0000BEEF);
    @(negedge clk);
    n0 = nlog;
    opr_req = 1'b1; opr_we = 1'b0; opr_seg = 16'h0900; opr_off = 16'h0101;
    while (nlog < n0 + 1 || log_we[(nlog - 1) % 64] || log_addr[(nlog - 1) % 64] != phys(16'h0900, 16'h0101))
      @(negedge clk);
    opr_req = 1'b0;
    @(negedge clk);
    chk(last_rd == {mb(phys(16'h0900, 16'h0101) + 20'd1), mb(phys(16'h0900, 16'h0101))},
        "R8 operand read data", {16'd0, last_rd},
        {16'd0, mb(phys(16'h0900, 16'h0101) + 20'd1), mb(phys(16'h0900, 16'h0101))});

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule